// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Read-Cycle Start

This block is the digital half of an 8-bit successive-approximation converter. It drives a trial code to an external DAC and reads back a single comparator bit. Eight decisions, made one per clock from the most significant bit down, refine the trial code. The final code is then copied into an output latch that a microprocessor-style chip-select/read port returns on the data bus. Starting a conversion and reading a result are the same bus cycle. Driving `cs_n` and `rd_n` low together while the block is idle starts a new conversion. The block also makes the track/hold control for the external sampling capacitor.

Two read styles are selected by `mode_rom`. In wait-state mode (`mode_rom` = 0), the processor keeps the read asserted for the whole conversion and is held off by `busy_n`. The data bus stays disabled until the new code is in the latch, and then shows that code. In ROM mode (`mode_rom` = 1), the read completes at once and returns the code from the previous conversion, while a new conversion starts in the background.

The control is a four-state machine:
- IDLE: waiting.
- SETTLE: the trial code sits at half scale while the sample is being captured.
- DECIDE: one comparator decision per clock.
- LATCH: the result is copied into the output latch and the trial code is reloaded.

Its transitions are:
- start: IDLE to SETTLE, on a new read assertion.
- held: SETTLE to DECIDE, once track/hold is in hold.
- last: DECIDE to LATCH, after the decision on bit 0.
- done: LATCH to IDLE, unconditional.

Top module: `sar_bus_ctrl`

## Requirements
- R1: While `rst_n` is low and just after it, `busy_n` = 1, `dac_code` = 8'h80, `th_hold` = 0 and `data_out` = 8'h00. `data_oe` = 0 while no read is asserted.
- R2: A conversion is accepted at the first rising clock edge where, with the block idle, `cs_n` and `rd_n` are both low after not both being low at the previous edge. `busy_n` goes low at that edge (edge A).
- R3: From edge A until edge A+3 the trial code `dac_code` is half scale, 8'h80.
- R4: At edges A+4 through A+11, one decision is made per edge on the current trial bit, from bit 7 down to bit 0. The bit stays 1 if `cmp_hi` = 1 (input at or above the trial code) and is cleared otherwise. The next lower bit is set to 1 as the new trial.
- R5: After the eighth decision, `dac_code` holds the finished code. At edge A+12 that code is copied into the output latch and `busy_n` returns high.
- R6: At edge A+12 the trial code returns to 8'h80.
- R7: `th_hold` rises on the third falling clock edge after edge A. It stays high through all decisions and falls on the falling edge after `busy_n` returns high.
- R8: With `mode_rom` = 0, `data_oe` is low while `busy_n` is low even with the read asserted. Once `busy_n` is high with the read still asserted, `data_oe` = 1 and `data_out` shows the new code.
- R9: With `mode_rom` = 1, `data_oe` = 1 as soon as the read is asserted, and `data_out` shows the code from the previous conversion.
- R10: A read assertion made while `busy_n` is low is ignored: the conversion timing and result are unchanged. A read still held low when the conversion ends does not start another one.
- R11: `data_oe` is 0 whenever `cs_n` or `rd_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; decisions on rising edges, track/hold on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rom | input | 1 | 0 = wait-state read, 1 = ROM-style read |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_hi | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| th_hold | output | 1 | Track/hold control, 1 = hold |
| busy_n | output | 1 | Low while a conversion runs |
| data_out | output | WIDTH | Output latch contents |
| data_oe | output | 1 | Data bus drive enable (0 = high impedance) |

## Verification
The bench builds the block with its default width of 8 and a hold delay of three falling edges. At that size every input level from 0 to 255 can be converted. Each level is run in wait-state mode and again in ROM mode, and the bench checks every intermediate trial code against a masked copy of the input level. ROM-mode runs alternate with and without an extra read pulse in the middle of the conversion. This brings the bus-ignore rule and the previous-result return within reach for every code.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DECIDE = 2'd2,
        ST_LATCH  = 2'd3
    } sar_state_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       hold,
    input  logic       last_bit,
    output sar_state_t state,
    output logic       busy_n,
    output logic       decide_en,
    output logic       latch_en
);

    sar_state_t state_q;
    sar_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, held, last, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_SETTLE;
            ST_SETTLE: if (hold)     state_d = ST_DECIDE;
            ST_DECIDE: if (last_bit) state_d = ST_LATCH;
            ST_LATCH:                state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_n    = 1'b0;
        decide_en = 1'b0;
        latch_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_n    = 1'b1;
            ST_SETTLE: ;
            ST_DECIDE: decide_en = 1'b1;
            ST_LATCH:  latch_en  = 1'b1;
            default:   busy_n    = 1'b1;
        endcase
    end

    assign state = state_q;

    // R10
    no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE || state_q == ST_DECIDE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             decide_en,
    input  logic             reload,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] code,
    output logic             last_bit
);

    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [WIDTH-1:0] MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(WIDTH - 1);

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_d;
    logic [IDX_W-1:0] idx_q;

    // decision on the current trial bit, next lower bit becomes the trial
    always_comb begin
        code_d = code_q;
        for (int b = 0; b < WIDTH; b++) begin
            if (b == int'(idx_q))          code_d[b] = cmp_hi;
            else if (b + 1 == int'(idx_q)) code_d[b] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= MID_CODE;
            idx_q  <= TOP_IDX;
        end else if (reload) begin
            code_q <= MID_CODE;
            idx_q  <= TOP_IDX;
        end else if (decide_en) begin
            code_q <= code_d;
            if (idx_q != '0) idx_q <= idx_q - 1'b1;
        end
    end

    assign code     = code_q;
    assign last_bit = (idx_q == '0);

    // R4
    trial_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        decide_en |-> code_q[idx_q]);

    // R6
    mid_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (code_q == MID_CODE));

endmodule

// File: rtl/sar_track_hold.sv
module sar_track_hold #(
    parameter int HOLD_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hold
);

    localparam int CNT_W = $clog2(HOLD_EDGES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;

    // counts falling edges from the start of a conversion
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else if (!active) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else if (!hold_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HOLD_EDGES - 1)) hold_q <= 1'b1;
        end
    end

    assign hold = hold_q;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int HOLD_EDGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rom,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] dac_code,
    output logic             th_hold,
    output logic             busy_n,
    output logic [WIDTH-1:0] data_out,
    output logic             data_oe
);

    sar_state_t       state;
    logic             rd_act;
    logic             rd_act_q;
    logic             start;
    logic             decide_en;
    logic             latch_en;
    logic             last_bit;
    logic [WIDTH-1:0] code;
    logic [WIDTH-1:0] data_q;

    assign rd_act = ~cs_n & ~rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_act_q <= 1'b0;
        else        rd_act_q <= rd_act;
    end

    // a new read edge while idle starts a conversion
    assign start = rd_act & ~rd_act_q & busy_n;

    sar_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .hold     (th_hold),
        .last_bit (last_bit),
        .state    (state),
        .busy_n   (busy_n),
        .decide_en(decide_en),
        .latch_en (latch_en)
    );

    sar_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .decide_en(decide_en),
        .reload   (latch_en),
        .cmp_hi   (cmp_hi),
        .code     (code),
        .last_bit (last_bit)
    );

    sar_track_hold #(.HOLD_EDGES(HOLD_EDGES)) u_th (
        .clk   (clk),
        .rst_n (rst_n),
        .active(~busy_n),
        .hold  (th_hold)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (latch_en) data_q <= code;
    end

    assign dac_code = code;
    assign data_out = data_q;
    assign data_oe  = rd_act & (mode_rom | busy_n);

    // R5
    latch_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (data_q == $past(code)));

    // R7
    hold_in_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE) |-> th_hold);

    // R2
    start_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !busy_n);

endmodule

// File: tb/sar_bus_ctrl_test.sv
`timescale 1ns/1ps
module sar_bus_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_rom = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       cmp_hi;
    logic [7:0] dac_code;
    logic       th_hold;
    logic       busy_n;
    logic [7:0] data_out;
    logic       data_oe;
    logic [7:0] vin = 8'd0;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    // comparator model
    assign cmp_hi = (vin >= dac_code);

    sar_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mode_rom(mode_rom), .cs_n(cs_n), .rd_n(rd_n),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .th_hold(th_hold), .busy_n(busy_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] trial_after(input logic [7:0] v, input int j);
        logic [7:0] mask;
        mask = 8'hFF << (8 - j);
        return (v & mask) | (8'h80 >> j);
    endfunction

    task automatic convert(input logic [7:0] v, input bit rom, input bit glitch,
                           input logic [7:0] prev);
        @(posedge clk); #1;
        vin = v; mode_rom = rom; cs_n = 1'b0; rd_n = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #2;
            if (i == 0) begin
                chk(busy_n == 1'b0, "R2", busy_n, 0);
                if (rom) begin
                    chk(data_oe == 1'b1, "R9 oe", data_oe, 1);
                    chk(data_out == prev, "R9 data", data_out, prev);
                end else
                    chk(data_oe == 1'b0, "R8 oe busy", data_oe, 0);
            end
            if (i <= 3) chk(dac_code == 8'h80, "R3", dac_code, 8'h80);
            if (i >= 4 && i <= 10)
                chk(dac_code == trial_after(v, i - 3), "R4", dac_code, trial_after(v, i - 3));
            if (i == 11) chk(dac_code == v, "R5 final", dac_code, v);
            if (i < 12) chk(busy_n == 1'b0, "R10 busy", busy_n, 0);
            if (i == 12) begin
                chk(busy_n == 1'b1, "R5 done", busy_n, 1);
                chk(dac_code == 8'h80, "R6", dac_code, 8'h80);
                if (!rom) begin
                    chk(data_oe == 1'b1, "R8 oe ready", data_oe, 1);
                    chk(data_out == v, "R8 data", data_out, v);
                end else
                    chk(data_out == v, "R5 latch", data_out, v);
            end
            if (i == 13) chk(busy_n == 1'b1, "R10 no restart", busy_n, 1);
            if (rom && i == 1) begin cs_n = 1'b1; rd_n = 1'b1; end
            if (rom && i == 2) chk(data_oe == 1'b0, "R11", data_oe, 0);
            if (rom && glitch && i == 4) begin cs_n = 1'b0; rd_n = 1'b0; end
            if (rom && glitch && i == 5) begin cs_n = 1'b1; rd_n = 1'b1; end
            #2;
            chk(th_hold == (i >= 2 && i <= 11), "R7", th_hold, (i >= 2 && i <= 11));
        end
        cs_n = 1'b1; rd_n = 1'b1;
        #0.2;
        chk(data_oe == 1'b0, "R11 idle", data_oe, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(busy_n == 1'b1, "R1 busy", busy_n, 1);
        chk(dac_code == 8'h80, "R1 code", dac_code, 8'h80);
        chk(th_hold == 1'b0, "R1 hold", th_hold, 0);
        chk(data_out == 8'h00, "R1 data", data_out, 0);
        chk(data_oe == 1'b0, "R1 oe", data_oe, 0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(busy_n == 1'b1, "R1 after", busy_n, 1);
        for (int v = 0; v < 256; v++) convert(8'(v), 1'b0, 1'b0, 8'h00);
        for (int v = 0; v < 256; v++)
            convert(8'(v), 1'b1, v[0], (v == 0) ? 8'hFF : 8'(v - 1));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule